// File: doc/BRIEF.md
# Outstanding-Event Dead-Time Controller

This block decides centrally when the detector has to be held dead. It keeps a count of events that have been triggered but not yet fully taken in by every receiver node. Each trigger strobe raises the count by one. Completion is reported by single-cycle pulses that travel along a daisy chain of receiver nodes. Each node is store-and-forward: it passes a completion pulse downstream only when it has also finished receiving an event locally. A pulse leaving the last node therefore means that every node holds the event, and only that pulse lowers the count.

When the count reaches the dead level (7 by default), the dead flag goes high. This keeps one event of margin against front-end buffering that holds eight events, because another event may already be on its way. The flag drops as soon as the count falls below the dead level. There is no hysteresis.

The central counter is a three-state machine, with states `CS_EMPTY`, `CS_LIVE` and `CS_DEAD`, over a saturating count. Its transitions are:
- `EMPTY->LIVE` on a trigger.
- `LIVE->EMPTY` on a completion at count 1.
- `LIVE->DEAD` on a trigger at count DEAD_LEVEL-1.
- `DEAD->LIVE` on a completion at count DEAD_LEVEL.
- Otherwise each state loops on itself.

Each chain node is a three-state machine, with states `ND_BALANCED`, `ND_AHEAD_UP` and `ND_AHEAD_LOCAL`, plus a pending count. Its transitions are:
- `BALANCED->AHEAD_UP` on an upstream pulse alone.
- `BALANCED->AHEAD_LOCAL` on a local completion alone.
- `AHEAD_UP->BALANCED` and `AHEAD_LOCAL->BALANCED` when the last pending item is matched.
- Otherwise each state loops on itself.

Top module: `dtc_deadtime_ctrl`

## Requirements
- R1: A synchronous reset leaves the dead flag low, the underflow flag low, all chain outputs low, every node pending count at zero and the event count at zero.
- R2: Each trigger strobe with no coincident final-node pulse raises the count by one. The dead flag is high in the cycle after the edge on which the count reaches DEAD_LEVEL (7), and low while the count is 6 or less.
- R3: Node k drives its chain output bit k high for exactly one cycle. This happens on the clock edge after both an upstream pulse and a local completion are available to it. The upstream pulse comes from the chain input for node 0 and from bit k-1 for the other nodes. The two may arrive in either order, and a node never forwards on one of them alone.
- R4: A node stores several unmatched upstream pulses or local completions and emits exactly one pulse for each matched pair, never more pulses than either kind it has received.
- R5: A pulse on the last chain output bit lowers the count by one on the following edge, and the dead flag falls as soon as the count drops below DEAD_LEVEL.
- R6: A trigger in the same cycle as a last-node pulse leaves the count unchanged.
- R7: A last-node pulse at count zero leaves the count at zero and sets the underflow flag. The flag stays high until reset.
- R8: The count saturates at its maximum (15 by default); triggers beyond it are lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Trigger strobe, one event per high cycle |
| chain_in_i | input | 1 | Completion pulse entering the first node |
| node_done_i | input | NODES | Local event-complete strobe, one bit per node |
| dead_o | output | 1 | Dead-time flag |
| underflow_o | output | 1 | Sticky underflow error flag |
| chain_o | output | NODES | Forwarded completion pulse of each node; the top bit feeds the counter |

## Verification
The assertions assume that the inputs are single-cycle strobes, each counted once per high cycle. They also assume that reset is held for at least one edge before any check matters, and that over a run fewer than about a million pulses reach any node, so the checker's running totals never wrap. The stimulus drives every strobe for whole cycles from the falling edge and applies reset before each scenario. It also keeps each node's unmatched backlog at three or fewer, below the pending saturation point. The order in which upstream pulses and local completions reach a node is varied on purpose, and so is the alignment of a trigger with a final-node pulse.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    typedef enum logic [1:0] {
        CS_EMPTY = 2'd0,
        CS_LIVE  = 2'd1,
        CS_DEAD  = 2'd2
    } cnt_state_t;

    typedef enum logic [1:0] {
        ND_BALANCED    = 2'd0,
        ND_AHEAD_UP    = 2'd1,
        ND_AHEAD_LOCAL = 2'd2
    } node_state_t;

endpackage

// File: rtl/dtc_chain_node.sv
module dtc_chain_node
    import dtc_pkg::*;
#(
    parameter int PEND_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic up_pulse_i,
    input  logic local_done_i,
    output logic fwd_pulse_o
);

    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};
    localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

    node_state_t       st_q, st_n;
    logic [PEND_W-1:0] pend_q, pend_n;
    logic              fire_q, fire_n;

    // Next-state and next-pending logic
    always_comb begin
        st_n   = st_q;
        pend_n = pend_q;
        fire_n = 1'b0;
        unique case (st_q)
            ND_BALANCED: begin
                if (up_pulse_i && local_done_i) begin
                    fire_n = 1'b1;
                end else if (up_pulse_i) begin
                    st_n   = ND_AHEAD_UP;
                    pend_n = PEND_ONE;
                end else if (local_done_i) begin
                    st_n   = ND_AHEAD_LOCAL;
                    pend_n = PEND_ONE;
                end
            end
            ND_AHEAD_UP: begin
                if (local_done_i) begin
                    fire_n = 1'b1;
                    if (!up_pulse_i) begin
                        pend_n = pend_q - PEND_ONE;
                        if (pend_q == PEND_ONE) st_n = ND_BALANCED;
                    end
                end else if (up_pulse_i && pend_q != PEND_MAX) begin
                    pend_n = pend_q + PEND_ONE;
                end
            end
            ND_AHEAD_LOCAL: begin
                if (up_pulse_i) begin
                    fire_n = 1'b1;
                    if (!local_done_i) begin
                        pend_n = pend_q - PEND_ONE;
                        if (pend_q == PEND_ONE) st_n = ND_BALANCED;
                    end
                end else if (local_done_i && pend_q != PEND_MAX) begin
                    pend_n = pend_q + PEND_ONE;
                end
            end
            default: begin
                st_n   = ND_BALANCED;
                pend_n = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ND_BALANCED;
            pend_q <= '0;
            fire_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            pend_q <= pend_n;
            fire_q <= fire_n;
        end
    end

    // Outputs
    always_comb begin
        fwd_pulse_o = fire_q;
    end

endmodule

// File: rtl/dtc_event_counter.sv
module dtc_event_counter
    import dtc_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int DEAD_LEVEL = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    input  logic done_i,
    output logic dead_o,
    output logic underflow_o
);

    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] LVL      = CNT_W'(DEAD_LEVEL);
    localparam logic [CNT_W-1:0] LVL_LESS = CNT_W'(DEAD_LEVEL - 1);

    cnt_state_t       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             uf_q, uf_n;
    logic             inc, dec;

    always_comb begin
        inc = trig_i && !done_i;
        dec = done_i && !trig_i;
    end

    // Next-state and next-count logic
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        uf_n  = uf_q;
        unique case (st_q)
            CS_EMPTY: begin
                if (inc) begin
                    cnt_n = CNT_ONE;
                    st_n  = CS_LIVE;
                end else if (dec) begin
                    uf_n = 1'b1;
                end
            end
            CS_LIVE: begin
                if (inc) begin
                    cnt_n = cnt_q + CNT_ONE;
                    if (cnt_q == LVL_LESS) st_n = CS_DEAD;
                end else if (dec) begin
                    cnt_n = cnt_q - CNT_ONE;
                    if (cnt_q == CNT_ONE) st_n = CS_EMPTY;
                end
            end
            CS_DEAD: begin
                if (inc) begin
                    if (cnt_q != CNT_MAX) cnt_n = cnt_q + CNT_ONE;
                end else if (dec) begin
                    cnt_n = cnt_q - CNT_ONE;
                    if (cnt_q == LVL) st_n = CS_LIVE;
                end
            end
            default: begin
                st_n  = CS_EMPTY;
                cnt_n = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CS_EMPTY;
            cnt_q <= '0;
            uf_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            uf_q  <= uf_n;
        end
    end

    // Outputs
    always_comb begin
        dead_o      = (st_q == CS_DEAD);
        underflow_o = uf_q;
    end

endmodule

// File: rtl/dtc_deadtime_ctrl.sv
module dtc_deadtime_ctrl
    import dtc_pkg::*;
#(
    parameter int NODES      = 4,
    parameter int CNT_W      = 4,
    parameter int DEAD_LEVEL = 7,
    parameter int PEND_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic             chain_in_i,
    input  logic [NODES-1:0] node_done_i,
    output logic             dead_o,
    output logic             underflow_o,
    output logic [NODES-1:0] chain_o
);

    localparam int LAST = NODES - 1;

    logic [NODES-1:0] up_link;
    logic [NODES-1:0] fwd_link;

    generate
        for (genvar k = 0; k < NODES; k++) begin : g_node
            if (k == 0) begin : g_head
                assign up_link[k] = chain_in_i;
            end else begin : g_body
                assign up_link[k] = fwd_link[k-1];
            end
            dtc_chain_node #(
                .PEND_W(PEND_W)
            ) u_node (
                .clk         (clk),
                .rst         (rst),
                .up_pulse_i  (up_link[k]),
                .local_done_i(node_done_i[k]),
                .fwd_pulse_o (fwd_link[k])
            );
        end
    endgenerate

    dtc_event_counter #(
        .CNT_W     (CNT_W),
        .DEAD_LEVEL(DEAD_LEVEL)
    ) u_counter (
        .clk        (clk),
        .rst        (rst),
        .trig_i     (trig_i),
        .done_i     (fwd_link[LAST]),
        .dead_o     (dead_o),
        .underflow_o(underflow_o)
    );

    assign chain_o = fwd_link;

endmodule

// File: rtl/dtc_deadtime_checker.sv
module dtc_deadtime_checker #(
    parameter int NODES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             trig_i,
    input logic             chain_in_i,
    input logic [NODES-1:0] node_done_i,
    input logic             dead_o,
    input logic             underflow_o,
    input logic [NODES-1:0] chain_o
);

    localparam int LAST  = NODES - 1;
    localparam int TOT_W = 20;

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!dead_o && !underflow_o && chain_o == '0)); // R1
    AST_DEAD_RISE: assert property (@(posedge clk) disable iff (rst) $rose(dead_o) |-> ($past(trig_i) && !$past(chain_o[LAST]))); // R2
    AST_DEAD_FALL: assert property (@(posedge clk) disable iff (rst) $fell(dead_o) |-> ($past(chain_o[LAST]) && !$past(trig_i))); // R5
    AST_HOLD_ON_BOTH: assert property (@(posedge clk) disable iff (rst) (trig_i && chain_o[LAST]) |=> $stable(dead_o)); // R6
    AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(underflow_o) |-> ($past(chain_o[LAST]) && !$past(dead_o))); // R7
    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst) underflow_o |=> underflow_o); // R7

    generate
        for (genvar k = 0; k < NODES; k++) begin : g_tot
            logic [TOT_W-1:0] up_tot, loc_tot, out_tot;
            logic             up_bit;
            if (k == 0) begin : g_h
                assign up_bit = chain_in_i;
            end else begin : g_b
                assign up_bit = chain_o[k-1];
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    up_tot  <= '0;
                    loc_tot <= '0;
                    out_tot <= '0;
                end else begin
                    up_tot  <= up_tot  + TOT_W'(up_bit);
                    loc_tot <= loc_tot + TOT_W'(node_done_i[k]);
                    out_tot <= out_tot + TOT_W'(chain_o[k]);
                end
            end
            AST_FWD_AFTER_UP: assert property (@(posedge clk) disable iff (rst) out_tot <= up_tot); // R4
            AST_FWD_AFTER_LOCAL: assert property (@(posedge clk) disable iff (rst) out_tot <= loc_tot); // R3
        end
    endgenerate

endmodule

bind dtc_deadtime_ctrl dtc_deadtime_checker #(.NODES(NODES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .trig_i     (trig_i),
    .chain_in_i (chain_in_i),
    .node_done_i(node_done_i),
    .dead_o     (dead_o),
    .underflow_o(underflow_o),
    .chain_o    (chain_o)
);

// File: tb/dtc_deadtime_ctrl_test.sv
module dtc_deadtime_ctrl_test;

    localparam int NODES = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig_i = 1'b0;
    logic             chain_in_i = 1'b0;
    logic [NODES-1:0] node_done_i = '0;
    logic             dead_o, underflow_o;
    logic [NODES-1:0] chain_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dtc_deadtime_ctrl #(.NODES(NODES)) uut (
        .clk(clk), .rst(rst), .trig_i(trig_i), .chain_in_i(chain_in_i),
        .node_done_i(node_done_i), .dead_o(dead_o), .underflow_o(underflow_o),
        .chain_o(chain_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; trig_i = 1'b0; chain_in_i = 1'b0; node_done_i = '0;
        step(3);
        rst = 1'b0;
    endtask

    task automatic triggers(input int n);
        for (int i = 0; i < n; i++) begin
            trig_i = 1'b1; step(1); trig_i = 1'b0;
        end
    endtask

    // one event completed at every node at once; count updated on return
    task automatic complete_event();
        chain_in_i = 1'b1; node_done_i = '1; step(1);
        chain_in_i = 1'b0; node_done_i = '0; step(NODES);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "dead after reset", dead_o, 0);
        chk("R1", "underflow after reset", underflow_o, 0);
        chk("R1", "chain after reset", chain_o, 0);
    endtask

    task automatic t_threshold();
        do_reset();
        triggers(6);
        chk("R2", "dead at count 6", dead_o, 0);
        triggers(1);
        chk("R2", "dead at count 7", dead_o, 1);
        triggers(1);
        chk("R2", "dead at count 8", dead_o, 1);
        complete_event();
        chk("R5", "dead at count 7 after drain", dead_o, 1);
        complete_event();
        chk("R5", "dead at count 6 after drain", dead_o, 0);
        for (int i = 0; i < 6; i++) complete_event();
        chk("R5", "no underflow draining to zero", underflow_o, 0);
        complete_event();
        chk("R7", "underflow after extra completion", underflow_o, 1);
    endtask

    task automatic t_order();
        do_reset();
        triggers(1);
        node_done_i = '1; step(1); node_done_i = '0; step(3);
        chk("R3", "no forward on local alone", chain_o, 0);
        chain_in_i = 1'b1; step(1); chain_in_i = 1'b0;
        chk("R3", "node0 forward", chain_o, 4'b0001);
        step(1); chk("R3", "node1 forward", chain_o, 4'b0010);
        step(1); chk("R3", "node2 forward", chain_o, 4'b0100);
        step(1); chk("R3", "node3 forward", chain_o, 4'b1000);
        step(1); chk("R7", "no underflow at balanced drain", underflow_o, 0);
        triggers(1);
        chain_in_i = 1'b1; step(1); chain_in_i = 1'b0; step(3);
        chk("R3", "no forward on upstream alone", chain_o, 0);
        node_done_i = 4'b0001; step(1); node_done_i = '0;
        chk("R3", "node0 forward after late local", chain_o, 4'b0001);
        step(1);
        chk("R3", "node1 waits for its local", chain_o, 0);
        node_done_i = 4'b1110; step(1); node_done_i = '0;
        chk("R3", "node1 forward after late local", chain_o, 4'b0010);
        step(2);
        chk("R3", "node3 forward", chain_o, 4'b1000);
        step(1);
        chk("R7", "count balanced, no underflow", underflow_o, 0);
    endtask

    task automatic t_accum();
        int n;
        do_reset();
        triggers(3);
        node_done_i = 4'b1110; step(3); node_done_i = '0;
        chain_in_i = 1'b1; step(3); chain_in_i = 1'b0;
        step(2);
        chk("R4", "stored pulses held back", chain_o, 0);
        n = 0;
        for (int i = 0; i < 12; i++) begin
            node_done_i = (i < 3) ? 4'b0001 : 4'b0000;
            @(negedge clk);
            if (chain_o[NODES-1]) n++;
        end
        node_done_i = '0;
        chk("R4", "last-node pulses for three pairs", n, 3);
        chk("R4", "no underflow after three matched", underflow_o, 0);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            node_done_i = (i == 0) ? 4'b0001 : 4'b0000;
            @(negedge clk);
            if (chain_o != '0) n++;
        end
        node_done_i = '0;
        chk("R4", "unmatched local emits nothing", n, 0);
        chk("R4", "count untouched by unmatched local", underflow_o, 0);
    endtask

    task automatic t_simul();
        do_reset();
        triggers(7);
        chk("R2", "dead before coincidence", dead_o, 1);
        chain_in_i = 1'b1; node_done_i = '1; step(1);
        chain_in_i = 1'b0; node_done_i = '0; step(NODES - 1);
        chk("R3", "last-node pulse present", chain_o[NODES-1], 1);
        trig_i = 1'b1; step(1); trig_i = 1'b0;
        chk("R6", "dead held on coincidence", dead_o, 1);
        complete_event();
        chk("R6", "count was held at 7", dead_o, 0);
    endtask

    task automatic t_underflow();
        do_reset();
        complete_event();
        chk("R7", "underflow set at zero", underflow_o, 1);
        chk("R7", "count stays zero, not dead", dead_o, 0);
        triggers(6);
        chk("R7", "count restarted from zero", dead_o, 0);
        triggers(1);
        chk("R7", "dead at 7 after underflow", dead_o, 1);
        chk("R7", "underflow sticky", underflow_o, 1);
        do_reset();
        chk("R1", "reset clears underflow", underflow_o, 0);
    endtask

    task automatic t_saturate();
        do_reset();
        triggers(20);
        for (int i = 0; i < 8; i++) complete_event();
        chk("R8", "dead at saturated count minus 8", dead_o, 1);
        complete_event();
        chk("R8", "live at saturated count minus 9", dead_o, 0);
    endtask

    initial begin
        t_reset();
        t_threshold();
        t_order();
        t_accum();
        t_simul();
        t_underflow();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule